// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational block picks the address of the next instruction for a 32-bit load-store processor with one branch delay slot. It receives the current program counter, the fetched instruction word and the two register operands read for it. It decodes the control-transfer opcodes and does the target arithmetic. A program-counter register outside the block captures its result on every clock edge.

Conditional branches test either two registers against each other or one register against zero, comparing as signed values. A taken branch adds a scaled signed offset to the address of the delay-slot instruction. Absolute jumps keep the top region bits of that address. A register jump goes straight to the operand value. A jump-and-link also asks for the return address, which skips the delay slot, to be written into the fixed link register. Every other instruction, and every branch that is not taken, simply moves on to the next word.

Top module: `next_pc_unit`

## Requirements
- R1: When the opcode (instruction bits 31:26) is not 0x1 to 0x7 and the instruction is not a register jump, the next PC is PC+4 (modulo 2^32).
- R2: Opcode 0x4 is taken exactly when the rs and rt operands are equal; opcode 0x5 is taken exactly when they differ. A branch that is not taken gives PC+4.
- R3: The target of a taken conditional branch is PC+4 plus the sign-extended 16-bit field in bits 15:0 shifted left by 2, with the result wrapping modulo 2^32.
- R4: Opcode 0x1 uses the rt field (bits 20:16) as a sub-opcode: 0 branches if rs < 0, 1 branches if rs >= 0, and any other value gives PC+4.
- R5: Opcode 0x6 branches if rs <= 0 and opcode 0x7 branches if rs > 0, both as signed values and only when the rt field is 0; a nonzero rt field gives PC+4.
- R6: Opcode 0x2 sets the next PC to bits 31:28 of PC+4 followed by the 26-bit field in bits 25:0 and two zero bits.
- R7: Opcode 0x3 jumps to the same target as R6, raises the link write enable, and drives PC+8 (modulo 2^32) as link data with link index 31.
- R8: The link write enable is low for every opcode other than 0x3, including the register jump.
- R9: Opcode 0x0 with function code 0x08 (bits 5:0) sets the next PC to the rs operand; opcode 0x0 with any other function code gives PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value read from the register named in bits 25:21 |
| rt_val_i | input | 32 | Value read from the register named in bits 20:16 |
| next_pc_o | output | 32 | Address of the next instruction |
| link_we_o | output | 1 | Write enable for the return address |
| link_addr_o | output | 5 | Destination index for the return address |
| link_data_o | output | 32 | Return address (PC+8) |

## Verification
The bench builds the block with its default parameter, so the link index is 31, and it checks that value on every linking case. With that setting the vector table reaches each opcode and sub-opcode on both the taken and the not-taken side. It also covers the signed edges at 0, -1, the most negative and the most positive operand. It adds wrap-around of the branch sum and of the link value at the top of the address space, and a region change of the jump target when PC+4 crosses a 256 MB boundary.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int LINK_REG = 31
) (
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        link_we_o,
  output logic [4:0]  link_addr_o,
  output logic [31:0] link_data_o
);

  localparam logic [4:0] LINK_IDX = 5'(LINK_REG);

  logic [5:0]  op;
  logic [4:0]  sub;
  logic [5:0]  fn;
  logic [31:0] seq_pc;
  logic [31:0] br_pc;
  logic [31:0] jmp_pc;
  logic        same;
  logic        neg;
  logic        zero;
  logic        take;

  assign op     = instr_i[31:26];
  assign sub    = instr_i[20:16];
  assign fn     = instr_i[5:0];
  assign seq_pc = pc_i + 32'd4;
  assign br_pc  = seq_pc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], instr_i[25:0], 2'b00};
  assign same   = (rs_val_i == rt_val_i);
  assign neg    = rs_val_i[31];
  assign zero   = (rs_val_i == 32'd0);

  always_comb begin
    take = 1'b0;
    unique case (op)
      6'h01:   take = (sub == 5'd0) ? neg : (sub == 5'd1) ? !neg : 1'b0;
      6'h04:   take = same;
      6'h05:   take = !same;
      6'h06:   take = (sub == 5'd0) && (neg || zero);
      6'h07:   take = (sub == 5'd0) && !neg && !zero;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    if (op == 6'h02 || op == 6'h03)
      next_pc_o = jmp_pc;
    else if (op == 6'h00 && fn == 6'h08)
      next_pc_o = rs_val_i;
    else if (take)
      next_pc_o = br_pc;
    else
      next_pc_o = seq_pc;
  end

  assign link_we_o   = (op == 6'h03);
  assign link_addr_o = LINK_IDX;
  assign link_data_o = pc_i + 32'd8;

endmodule

module next_pc_unit_chk (
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [31:0] next_pc_o,
  input logic        link_we_o,
  input logic [4:0]  link_addr_o,
  input logic [31:0] link_data_o
);
  logic [5:0]  c_op;
  logic [31:0] c_pc4;
  assign c_op  = instr_i[31:26];
  assign c_pc4 = pc_i + 32'd4;

  always_comb begin
    if ((c_op == 6'h00 && instr_i[5:0] != 6'h08) || c_op > 6'h07)
      assert_seq_R1: assert (next_pc_o == c_pc4);
    if (c_op == 6'h04 && rs_val_i != rt_val_i)
      assert_beq_miss_R2: assert (next_pc_o == c_pc4);
    if (c_op == 6'h05 && rs_val_i == rt_val_i)
      assert_bne_miss_R2: assert (next_pc_o == c_pc4);
    if (c_op == 6'h02 || c_op == 6'h03)
      assert_region_R6: assert (next_pc_o[31:28] == c_pc4[31:28] && next_pc_o[1:0] == 2'b00);
    if (link_we_o)
      assert_link_val_R7: assert (link_data_o == c_pc4 + 32'd4 && link_addr_o == 5'd31);
    if (link_we_o)
      assert_link_only_R8: assert (c_op == 6'h03);
    if (c_op == 6'h00 && instr_i[5:0] == 6'h08)
      assert_jr_R9: assert (next_pc_o == rs_val_i);
  end
endmodule

bind next_pc_unit next_pc_unit_chk u_chk (.*);

// File: tb/sim_next_pc_unit.sv
module sim_next_pc_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc, instr, rs, rt;
  logic [31:0] next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_addr;

  next_pc_unit u0 (
    .pc_i(pc), .instr_i(instr), .rs_val_i(rs), .rt_val_i(rt),
    .next_pc_o(next_pc), .link_we_o(link_we),
    .link_addr_o(link_addr), .link_data_o(link_data)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam int N = 21;
  localparam logic [31:0] V_PC [N] = '{
    32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000,
    32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000,
    32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000, 32'h00001000,
    32'hA0000FFC, 32'hFFFFFFFC, 32'h00400000, 32'h00001000, 32'h00001000,
    32'hFFFFFFF8};
  localparam logic [31:0] V_IN [N] = '{
    {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20},
    {6'h04, 5'd1, 5'd2, 16'h0003},
    {6'h04, 5'd1, 5'd2, 16'h0003},
    {6'h05, 5'd1, 5'd2, 16'hFFFE},
    {6'h05, 5'd1, 5'd2, 16'hFFFE},
    {6'h01, 5'd1, 5'd0, 16'h0010},
    {6'h01, 5'd1, 5'd0, 16'h0010},
    {6'h01, 5'd1, 5'd1, 16'h0010},
    {6'h01, 5'd1, 5'd1, 16'h0010},
    {6'h01, 5'd1, 5'd5, 16'h0010},
    {6'h06, 5'd1, 5'd0, 16'h0010},
    {6'h06, 5'd1, 5'd0, 16'h0010},
    {6'h07, 5'd1, 5'd0, 16'h0010},
    {6'h07, 5'd1, 5'd0, 16'h0010},
    {6'h07, 5'd1, 5'd3, 16'h0010},
    {6'h02, 26'h0123456},
    {6'h02, 26'h3FFFFFF},
    {6'h03, 26'h0000100},
    {6'h00, 5'd4, 5'd0, 5'd0, 5'd0, 6'h08},
    {6'h00, 5'd4, 5'd0, 5'd31, 5'd0, 6'h09},
    {6'h04, 5'd1, 5'd2, 16'h0001}};
  localparam logic [31:0] V_RS [N] = '{
    32'd5, 32'd7, 32'd7, 32'd7, 32'd7,
    32'h80000000, 32'd0, 32'd0, 32'hFFFFFFFF, 32'd0,
    32'd0, 32'd1, 32'h7FFFFFFF, 32'h80000000, 32'd5,
    32'd0, 32'd0, 32'd0, 32'h12345678, 32'h12345678,
    32'd9};
  localparam logic [31:0] V_RT [N] = '{
    32'd5, 32'd7, 32'd8, 32'd8, 32'd7,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
    32'd9};
  localparam logic [31:0] V_NPC [N] = '{
    32'h00001004, 32'h00001010, 32'h00001004, 32'h00000FFC, 32'h00001004,
    32'h00001044, 32'h00001004, 32'h00001044, 32'h00001004, 32'h00001004,
    32'h00001044, 32'h00001004, 32'h00001044, 32'h00001004, 32'h00001004,
    32'hA048D158, 32'h0FFFFFFC, 32'h00000400, 32'h12345678, 32'h00001004,
    32'h00000000};
  localparam string V_TAG [N] = '{
    "R1", "R2", "R2", "R3", "R2", "R4", "R4", "R4", "R4", "R4",
    "R5", "R5", "R5", "R5", "R5", "R6", "R6", "R7", "R9", "R9", "R3"};

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pc = p; instr = i; rs = a; rt = b;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    pc = '0; instr = '0; rs = '0; rt = '0;
    // idle state, all-zero inputs: R1, R8
    apply(32'd0, 32'd0, 32'd0, 32'd0);
    chk("R1", "idle next", next_pc, 32'h00000004);
    chk("R8", "idle we", {31'd0, link_we}, 32'd0);

    for (int k = 0; k < N; k++) begin
      apply(V_PC[k], V_IN[k], V_RS[k], V_RT[k]);
      chk(V_TAG[k], $sformatf("vec%0d next", k), next_pc, V_NPC[k]);
      if (V_IN[k][31:26] == 6'h03) begin
        chk("R7", $sformatf("vec%0d we", k), {31'd0, link_we}, 32'd1);
        chk("R7", $sformatf("vec%0d link", k), link_data, V_PC[k] + 32'd8);
        chk("R7", $sformatf("vec%0d idx", k), {27'd0, link_addr}, 32'd31);
      end else begin
        chk("R8", $sformatf("vec%0d we", k), {31'd0, link_we}, 32'd0);
      end
    end

    // jal at the top of memory: link wraps, region bits come from PC+4 (R7)
    apply(32'hFFFFFFFC, {6'h03, 26'h0000003}, 32'd0, 32'd0);
    chk("R7", "wrap next", next_pc, 32'h0000000C);
    chk("R7", "wrap link", link_data, 32'h00000004);
    chk("R7", "wrap we", {31'd0, link_we}, 32'd1);

    // undefined opcode 0x08 and up falls through, no link (R1, R8)
    apply(32'h00002000, {6'h08, 5'd1, 5'd2, 16'h0040}, 32'd3, 32'd3);
    chk("R1", "op08 next", next_pc, 32'h00002004);
    chk("R8", "op08 we", {31'd0, link_we}, 32'd0);

    // most negative offset, equal operands (R3)
    apply(32'h00040000, {6'h04, 5'd1, 5'd2, 16'h8000}, 32'd1, 32'd1);
    chk("R3", "min offset", next_pc, 32'h00020004);

    // bgez on most positive, bltz on -1 (R4)
    apply(32'h00001000, {6'h01, 5'd1, 5'd1, 16'h0001}, 32'h7FFFFFFF, 32'd0);
    chk("R4", "bgez max", next_pc, 32'h00001008);
    apply(32'h00001000, {6'h01, 5'd1, 5'd0, 16'h0001}, 32'hFFFFFFFF, 32'd0);
    chk("R4", "bltz -1", next_pc, 32'h00001008);

    // blez on most negative; bgtz on 0 (R5)
    apply(32'h00001000, {6'h06, 5'd1, 5'd0, 16'h0001}, 32'h80000000, 32'd0);
    chk("R5", "blez min", next_pc, 32'h00001008);
    apply(32'h00001000, {6'h07, 5'd1, 5'd0, 16'h0001}, 32'd0, 32'd0);
    chk("R5", "bgtz 0", next_pc, 32'h00001004);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule